// File: doc/BRIEF.md
# Ethernet Controller Command and Status Register

This block is the main control point of a ring-based Ethernet controller. A host writes command bits to start initialization, enable the receive and transmit paths, or stop the controller. It reads back a status word that collects the events reported by the receive, transmit and initialization engines. Next to the command register sit three more registers: an interrupt mask, a mode register whose two low bits disable the receiver and transmitter, and a ring-length register that holds the two descriptor ring sizes as log2 values.

The engines report events as single-cycle pulses. Each pulse latches a sticky status bit, and the host clears that bit by writing a one to it. The block raises an interrupt request when a latched event is also selected by the mask and interrupts are enabled. It drives the receiver-on and transmitter-on enables, the effective ring sizes, a one-cycle pulse that asks the fetch engine to load its initialization block, and a one-cycle pulse that resets the ring positions.

Top module: `ecsr_top`

## Requirements
- R1: After reset, address 0 reads 0x0004 (only STOP set) and addresses 1, 2 and 3 read 0x0000. irq, rx_on, tx_on, ring_pos_rst and init_start are 0, and both ring sizes are 1.
- R2: A write to address 0 with bit 2 (STOP) set leaves the word holding only STOP and clears bits 14:0 otherwise. This includes IENA, STRT and INIT. INIT and STRT in the same write have no effect. ring_pos_rst is 1 for exactly the cycle after the write.
- R3: Writing 1 to a status bit in 14:8 (14 babble, 13 collision, 12 missed, 11 memory error, 10 receive, 9 transmit, 8 init done) clears it. Writing 0 leaves it unchanged.
- R4: Each event input pulse sets its status bit at the next edge. If a write-one-to-clear of the same bit happens in the same cycle, the event wins and the bit stays set.
- R5: A write to address 0 with bit 0 (INIT) set and STOP clear sets INIT and clears STOP. init_start is 1 for the cycle after the write. Writing 1 to bit 6 (IENA) sets it, and writing 0 does not clear it.
- R6: A write with bit 1 (STRT) set and STOP clear sets STRT and clears STOP. rx_on (status bit 5) equals STRT AND NOT mode bit 0. tx_on (status bit 4) equals STRT AND NOT mode bit 1. A mode write updates both at the same edge.
- R7: INTR (status bit 7) is 1 when any status bit in 14:8 is set together with the same bit of the mask register. It updates at the same edge as the status bits, and drops at the edge where the last masked cause is cleared. irq equals INTR AND IENA.
- R8: Status bit 15 reads as the OR of bits 14:11. Bit 3 always reads 0.
- R9: Address 3 stores the receive log2 length in bits 11:8 and the transmit log2 length in bits 15:12, and its other bits read 0. rx_ring_size and tx_ring_size equal 2^n, limited to 512 for n of 9 or more.
- R10: The address map is 0 command/status, 1 interrupt mask, 2 mode and 3 ring length. The mask stores only bits 14:8, and its other bits read 0. The mode register stores all 16 bits. bus_rdata shows the addressed register one cycle after the address, as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ev_rx_done | input | 1 | Receive complete pulse |
| ev_tx_done | input | 1 | Transmit complete pulse |
| ev_init_done | input | 1 | Initialization complete pulse |
| ev_missed | input | 1 | Missed frame pulse |
| ev_collision | input | 1 | Collision error pulse |
| ev_mem_err | input | 1 | Memory error pulse |
| ev_babble | input | 1 | Transmitter timeout pulse |
| irq | output | 1 | Interrupt request |
| rx_on | output | 1 | Receiver enable |
| tx_on | output | 1 | Transmitter enable |
| ring_pos_rst | output | 1 | Ring position reset pulse |
| init_start | output | 1 | Initialization fetch request pulse |
| rx_ring_size | output | 10 | Effective receive ring entries |
| tx_ring_size | output | 10 | Effective transmit ring entries |

## Verification
Directed cases cover single command writes and STOP combined with INIT and STRT, which separates the STOP override from ordinary command handling. They also cover an event coinciding with a clear of its own bit, which separates event priority from clear priority, and ring lengths on each side of the 512 clamp. A long random run then mixes writes to all four registers with sparse event pulses. Comparing the interrupt, enable and readback outputs every cycle against a bench model exposes ordering faults, such as a mask or mode write taking effect one cycle late.

// File: rtl/ecsr_pkg.sv
package ecsr_pkg;
  localparam int B_ERR   = 15;
  localparam int B_INTR  = 7;
  localparam int B_IENA  = 6;
  localparam int B_TDMD  = 3;
  localparam int B_STOP  = 2;
  localparam int B_STRT  = 1;
  localparam int B_INIT  = 0;
  localparam int ST_LO   = 8;   // lowest sticky status bit
  localparam int EV_N    = 7;   // sticky bits 14:8
  localparam int ERR_LO  = 3;   // st index of bit 11
  localparam int DIS_RX  = 0;
  localparam int DIS_TX  = 1;

  typedef enum logic [1:0] {
    SEL_CMD   = 2'd0,
    SEL_IMASK = 2'd1,
    SEL_MODE  = 2'd2,
    SEL_RING  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ecsr_status.sv
module ecsr_status
  import ecsr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [EV_N-1:0]   ev,
  input  logic [EV_N-1:0]   mask_d,
  input  logic [1:0]        dis_d,
  output logic [EV_N-1:0]   st_q,
  output logic              intr_q,
  output logic              iena_q,
  output logic              rxon_q,
  output logic              txon_q,
  output logic              stop_q,
  output logic              strt_q,
  output logic              init_q,
  output logic              irq_q,
  output logic              pos_rst_q,
  output logic              init_start_q
);
  logic [EV_N-1:0] clr, st_d;
  logic iena_d, stop_d, strt_d, init_d, intr_d, stop_cmd, init_cmd;

  always_comb begin
    clr      = '0;
    iena_d   = iena_q;
    stop_d   = stop_q;
    strt_d   = strt_q;
    init_d   = init_q;
    stop_cmd = cmd_wr & wdata[B_STOP];
    init_cmd = 1'b0;
    if (stop_cmd) begin
      clr    = '1;
      iena_d = 1'b0;
      strt_d = 1'b0;
      init_d = 1'b0;
      stop_d = 1'b1;
    end else if (cmd_wr) begin
      clr    = wdata[ST_LO +: EV_N];
      iena_d = iena_q | wdata[B_IENA];
      if (wdata[B_INIT]) begin
        init_d   = 1'b1;
        stop_d   = 1'b0;
        init_cmd = 1'b1;
      end
      if (wdata[B_STRT]) begin
        strt_d = 1'b1;
        stop_d = 1'b0;
      end
    end
    st_d   = (st_q & ~clr) | ev;
    intr_d = |(st_d & mask_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= '0;
      intr_q       <= 1'b0;
      iena_q       <= 1'b0;
      rxon_q       <= 1'b0;
      txon_q       <= 1'b0;
      stop_q       <= 1'b1;
      strt_q       <= 1'b0;
      init_q       <= 1'b0;
      irq_q        <= 1'b0;
      pos_rst_q    <= 1'b0;
      init_start_q <= 1'b0;
    end else begin
      st_q         <= st_d;
      intr_q       <= intr_d;
      iena_q       <= iena_d;
      rxon_q       <= strt_d & ~dis_d[DIS_RX];
      txon_q       <= strt_d & ~dis_d[DIS_TX];
      stop_q       <= stop_d;
      strt_q       <= strt_d;
      init_q       <= init_d;
      irq_q        <= intr_d & iena_d;
      pos_rst_q    <= stop_cmd;
      init_start_q <= init_cmd;
    end
  end
endmodule

// File: rtl/ecsr_cfg.sv
module ecsr_cfg
  import ecsr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LOG2_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [EV_N-1:0]   mask_q,
  output logic [EV_N-1:0]   mask_d,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] mode_d,
  output logic [LOG2_W-1:0] rxl_q,
  output logic [LOG2_W-1:0] txl_q,
  output logic [LOG2_W-1:0] rxl_d,
  output logic [LOG2_W-1:0] txl_d
);
  localparam int RX_LO = 8;
  localparam int TX_LO = RX_LO + LOG2_W;

  always_comb begin
    mask_d = mask_q;
    mode_d = mode_q;
    rxl_d  = rxl_q;
    txl_d  = txl_q;
    if (wr) begin
      case (sel)
        SEL_IMASK: mask_d = wdata[ST_LO +: EV_N];
        SEL_MODE:  mode_d = wdata;
        SEL_RING: begin
          rxl_d = wdata[RX_LO +: LOG2_W];
          txl_d = wdata[TX_LO +: LOG2_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      mode_q <= '0;
      rxl_q  <= '0;
      txl_q  <= '0;
    end else begin
      mask_q <= mask_d;
      mode_q <= mode_d;
      rxl_q  <= rxl_d;
      txl_q  <= txl_d;
    end
  end
endmodule

// File: rtl/ecsr_ring_size.sv
module ecsr_ring_size #(
  parameter int LOG2_W   = 4,
  parameter int MAX_LOG2 = 9,
  parameter int SIZE_W   = MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LOG2_W-1:0] log2_d,
  output logic [SIZE_W-1:0] size_q
);
  localparam logic [LOG2_W-1:0] CAP = LOG2_W'(MAX_LOG2);
  localparam logic [SIZE_W-1:0] ONE = SIZE_W'(1);
  logic [LOG2_W-1:0] n;

  always_comb n = (log2_d > CAP) ? CAP : log2_d;

  always_ff @(posedge clk) begin
    if (rst) size_q <= ONE;
    else     size_q <= ONE << n;
  end
endmodule

// File: rtl/ecsr_top.sv
module ecsr_top
  import ecsr_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int LOG2_W        = 4,
  parameter int RING_MAX_LOG2 = 9,
  parameter int SIZE_W        = RING_MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_rx_done,
  input  logic              ev_tx_done,
  input  logic              ev_init_done,
  input  logic              ev_missed,
  input  logic              ev_collision,
  input  logic              ev_mem_err,
  input  logic              ev_babble,
  output logic              irq,
  output logic              rx_on,
  output logic              tx_on,
  output logic              ring_pos_rst,
  output logic              init_start,
  output logic [SIZE_W-1:0] rx_ring_size,
  output logic [SIZE_W-1:0] tx_ring_size
);
  reg_sel_e            sel;
  logic [EV_N-1:0]     ev, mask_q, mask_d, st_q;
  logic [DATA_W-1:0]   mode_q, mode_d;
  logic [LOG2_W-1:0]   rxl_q, txl_q, rxl_d, txl_d;
  logic [LOG2_W-1:0]   log2_d [2];
  logic [SIZE_W-1:0]   size_q [2];
  logic intr_q, iena_q, stop_q, strt_q, init_q;

  assign sel = reg_sel_e'(bus_addr);
  assign ev  = {ev_babble, ev_collision, ev_missed, ev_mem_err,
                ev_rx_done, ev_tx_done, ev_init_done};

  ecsr_cfg #(.DATA_W(DATA_W), .LOG2_W(LOG2_W)) u_cfg (
    .clk(clk), .rst(rst), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
    .mask_q(mask_q), .mask_d(mask_d), .mode_q(mode_q), .mode_d(mode_d),
    .rxl_q(rxl_q), .txl_q(txl_q), .rxl_d(rxl_d), .txl_d(txl_d)
  );

  ecsr_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst), .cmd_wr(bus_wr && sel == SEL_CMD),
    .wdata(bus_wdata), .ev(ev), .mask_d(mask_d),
    .dis_d(mode_d[1:0]), .st_q(st_q), .intr_q(intr_q), .iena_q(iena_q),
    .rxon_q(rx_on), .txon_q(tx_on), .stop_q(stop_q), .strt_q(strt_q),
    .init_q(init_q), .irq_q(irq), .pos_rst_q(ring_pos_rst),
    .init_start_q(init_start)
  );

  assign log2_d[0] = rxl_d;
  assign log2_d[1] = txl_d;

  for (genvar g = 0; g < 2; g++) begin : g_ring
    ecsr_ring_size #(
      .LOG2_W(LOG2_W), .MAX_LOG2(RING_MAX_LOG2), .SIZE_W(SIZE_W)
    ) u_size (
      .clk(clk), .rst(rst), .log2_d(log2_d[g]), .size_q(size_q[g])
    );
  end

  assign rx_ring_size = size_q[0];
  assign tx_ring_size = size_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (sel)
        SEL_CMD:   bus_rdata <= {|st_q[EV_N-1:ERR_LO], st_q, intr_q, iena_q,
                                 rx_on, tx_on, 1'b0, stop_q, strt_q, init_q};
        SEL_IMASK: bus_rdata <= {1'b0, mask_q, 8'h00};
        SEL_MODE:  bus_rdata <= mode_q;
        default:   bus_rdata <= {txl_q, rxl_q, 8'h00};
      endcase
    end
  end
endmodule

// File: rtl/ecsr_checker.sv
module ecsr_checker (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        ev_rx_done,
  input logic        ev_babble,
  input logic        irq,
  input logic        rx_on,
  input logic        tx_on,
  input logic        ring_pos_rst,
  input logic        init_start,
  input logic [9:0]  rx_ring_size,
  input logic [9:0]  tx_ring_size,
  input logic [6:0]  st_q,
  input logic [6:0]  mask_q,
  input logic [15:0] mode_q
);
  p_stop_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd0 && bus_wdata[2]) |=>
      (ring_pos_rst && !rx_on && !tx_on && !init_start && !irq));

  p_w1c_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q[2] && !ev_rx_done &&
     !(bus_wr && bus_addr == 2'd0 && (bus_wdata[10] || bus_wdata[2])))
      |=> st_q[2]);

  p_event_rx_r4: assert property (@(posedge clk) disable iff (rst)
    ev_rx_done |=> st_q[2]);

  p_event_babl_r4: assert property (@(posedge clk) disable iff (rst)
    ev_babble |=> st_q[6]);

  p_rxon_r6: assert property (@(posedge clk) disable iff (rst)
    rx_on |-> !mode_q[0]);

  p_txon_r6: assert property (@(posedge clk) disable iff (rst)
    tx_on |-> !mode_q[1]);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|(st_q & mask_q)));

  p_ring_pow2_r9: assert property (@(posedge clk) disable iff (rst)
    ($countones(rx_ring_size) == 1) && ($countones(tx_ring_size) == 1));
endmodule

bind ecsr_top ecsr_checker u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ev_rx_done(ev_rx_done), .ev_babble(ev_babble),
  .irq(irq), .rx_on(rx_on), .tx_on(tx_on), .ring_pos_rst(ring_pos_rst),
  .init_start(init_start), .rx_ring_size(rx_ring_size),
  .tx_ring_size(tx_ring_size), .st_q(st_q), .mask_q(mask_q),
  .mode_q(mode_q)
);

// File: tb/ecsr_top_tb.sv
`timescale 1ns/1ps
module ecsr_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic [6:0]  evv = 7'h0;
  logic        irq, rx_on, tx_on, ring_pos_rst, init_start;
  logic [9:0]  rx_ring_size, tx_ring_size;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ecsr_top u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_rx_done(evv[2]), .ev_tx_done(evv[1]), .ev_init_done(evv[0]),
    .ev_missed(evv[4]), .ev_collision(evv[5]), .ev_mem_err(evv[3]),
    .ev_babble(evv[6]), .irq(irq), .rx_on(rx_on), .tx_on(tx_on),
    .ring_pos_rst(ring_pos_rst), .init_start(init_start),
    .rx_ring_size(rx_ring_size), .tx_ring_size(tx_ring_size)
  );

  // bench model, sticky bits indexed 0..6 for register bits 8..14
  logic [6:0]  m_st, m_mask;
  logic [15:0] m_mode;
  logic [3:0]  m_rxl, m_txl;
  logic m_iena, m_strt, m_init, m_stop, m_intr, m_irq, m_rxon, m_txon;
  logic m_prst, m_istart;

  function automatic logic [9:0] ring_entries(input logic [3:0] n);
    if (n >= 4'd9) return 10'd512;
    return 10'd1 << n;
  endfunction

  function automatic logic [15:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return {(m_st[6] | m_st[5] | m_st[4] | m_st[3]), m_st, m_intr,
                    m_iena, m_rxon, m_txon, 1'b0, m_stop, m_strt, m_init};
      2'd1: return {1'b0, m_mask, 8'h00};
      2'd2: return m_mode;
      default: return {m_txl, m_rxl, 8'h00};
    endcase
  endfunction

  task automatic model_reset();
    m_st = 0; m_mask = 0; m_mode = 0; m_rxl = 0; m_txl = 0;
    m_iena = 0; m_strt = 0; m_init = 0; m_stop = 1; m_intr = 0;
    m_irq = 0; m_rxon = 0; m_txon = 0; m_prst = 0; m_istart = 0;
  endtask

  task automatic model_step(input logic wr, input logic [1:0] a,
                            input logic [15:0] d, input logic [6:0] e);
    logic cmd;
    cmd = wr && (a == 2'd0);
    m_prst = 1'b0;
    m_istart = 1'b0;
    if (wr && a == 2'd1) m_mask = d[14:8];
    if (wr && a == 2'd2) m_mode = d;
    if (wr && a == 2'd3) begin m_rxl = d[11:8]; m_txl = d[15:12]; end
    if (cmd && d[2]) begin
      m_st = 0; m_iena = 0; m_strt = 0; m_init = 0; m_stop = 1;
      m_prst = 1'b1;
    end else if (cmd) begin
      m_st = m_st & ~d[14:8];
      if (d[6]) m_iena = 1'b1;
      if (d[0]) begin m_init = 1'b1; m_stop = 1'b0; m_istart = 1'b1; end
      if (d[1]) begin m_strt = 1'b1; m_stop = 1'b0; end
    end
    m_st   = m_st | e;
    m_intr = (m_st & m_mask) != 0;
    m_irq  = m_intr & m_iena;
    m_rxon = m_strt & ~m_mode[0];
    m_txon = m_strt & ~m_mode[1];
  endtask

  task automatic chk(input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // one cycle: drive at the falling edge, sample at the next falling edge
  task automatic step(input logic wr, input logic [1:0] a,
                      input logic [15:0] d, input logic [6:0] e);
    logic [15:0] exp_rd;
    bus_wr = wr; bus_addr = a; bus_wdata = d; evv = e;
    exp_rd = model_read(a);
    model_step(wr, a, d, e);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; evv = 7'h0;
    chk("R10 readback", bus_rdata, exp_rd);
    chk("R7 irq", {15'h0, irq}, {15'h0, m_irq});
    chk("R6 rx_on", {15'h0, rx_on}, {15'h0, m_rxon});
    chk("R6 tx_on", {15'h0, tx_on}, {15'h0, m_txon});
    chk("R2 ring_pos_rst", {15'h0, ring_pos_rst}, {15'h0, m_prst});
    chk("R5 init_start", {15'h0, init_start}, {15'h0, m_istart});
    chk("R9 rx size", {6'h0, rx_ring_size}, {6'h0, ring_entries(m_rxl)});
    chk("R9 tx size", {6'h0, tx_ring_size}, {6'h0, ring_entries(m_txl)});
  endtask

  task automatic rd(input logic [1:0] a, input string tag,
                    input logic [15:0] exp);
    step(1'b0, a, 16'h0, 7'h0);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20.0 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic [6:0]  e;
    logic        w;
    logic [1:0]  a;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 rx/tx on", {14'h0, rx_on, tx_on}, 16'h0);
    rd(2'd0, "R1 status", 16'h0004);
    rd(2'd1, "R1 mask", 16'h0000);
    rd(2'd2, "R1 mode", 16'h0000);
    rd(2'd3, "R1 ring", 16'h0000);
    chk("R1 sizes", {rx_ring_size[5:0], tx_ring_size}, {6'd1, 10'd1});

    // R5 R6 init + start + iena
    step(1'b1, 2'd0, 16'h0043, 7'h0);
    chk("R5 init_start pulse", {15'h0, init_start}, 16'h1);
    chk("R6 both on", {14'h0, rx_on, tx_on}, 16'h3);
    step(1'b0, 2'd0, 16'h0, 7'h0);
    chk("R5 init_start one cycle", {15'h0, init_start}, 16'h0);
    rd(2'd0, "R5 R6 status", 16'h0073);
    step(1'b1, 2'd0, 16'h0000, 7'h0);
    rd(2'd0, "R5 iena kept on zero write", 16'h0073);

    // R7 masked receive event raises irq
    step(1'b1, 2'd1, 16'hFFFF, 7'h0);
    rd(2'd1, "R10 mask bits", 16'h7F00);
    step(1'b0, 2'd0, 16'h0, 7'b0000100);
    chk("R7 irq on masked event", {15'h0, irq}, 16'h1);

    // R4 event beats clear
    step(1'b1, 2'd0, 16'h0400, 7'b0000100);
    rd(2'd0, "R4 event wins", 16'h04F3);

    // R3 clear drops cause and irq
    step(1'b1, 2'd0, 16'h0400, 7'h0);
    chk("R3 irq dropped", {15'h0, irq}, 16'h0);
    rd(2'd0, "R3 cleared", 16'h0073);

    // R6 mode disables receiver
    step(1'b1, 2'd2, 16'h0001, 7'h0);
    chk("R6 mode dis rx", {14'h0, rx_on, tx_on}, 16'h1);
    step(1'b1, 2'd2, 16'h0002, 7'h0);
    chk("R6 mode dis tx", {14'h0, rx_on, tx_on}, 16'h2);

    // R8 error summary and unmasked event
    step(1'b1, 2'd1, 16'h0000, 7'h0);
    step(1'b0, 2'd0, 16'h0, 7'b1000000);
    chk("R7 unmasked no irq", {15'h0, irq}, 16'h0);
    rd(2'd0, "R8 err summary", 16'hC063);
    step(1'b1, 2'd0, 16'h400C, 7'h0);
    step(1'b0, 2'd0, 16'h0, 7'h0);
    chk("R2 second stop", {15'h0, ring_pos_rst}, 16'h0);

    // R2 stop overrides init and start
    step(1'b1, 2'd0, 16'h0043, 7'b0001000);
    step(1'b1, 2'd0, 16'h0047, 7'h0);
    chk("R2 pos reset", {15'h0, ring_pos_rst}, 16'h1);
    chk("R2 no init_start", {15'h0, init_start}, 16'h0);
    rd(2'd0, "R2 only stop", 16'h0004);

    // R9 ring clamp
    step(1'b1, 2'd3, 16'hF3A5, 7'h0);
    chk("R9 rx 8", {6'h0, rx_ring_size}, 16'd8);
    chk("R9 tx clamp", {6'h0, tx_ring_size}, 16'd512);
    rd(2'd3, "R9 readback", 16'hF300);
    step(1'b1, 2'd3, 16'h8900, 7'h0);
    chk("R9 exact 512", {6'h0, rx_ring_size}, 16'd512);
    chk("R9 tx 256", {6'h0, tx_ring_size}, 16'd256);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      w = ($urandom % 3) == 0;
      a = 2'($urandom % 4);
      d = 16'($urandom);
      if (a == 2'd0 && ($urandom % 8) != 0) d[2] = 1'b0;
      for (int b = 0; b < 7; b++) e[b] = ($urandom % 8) == 0;
      step(w, a, d, e);
    end

    finish_run();
  end
endmodule